// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a clocked host and an asynchronous byte-wide static RAM of 128K locations. The host asks for one byte at a time with a request pulse, a read/write flag, a 17-bit location and a write byte. The sequencer then drives the RAM's address lines, its two chip selects (one active low, one active high), its write strobe, its output enable and its shared data bus. It spaces every edge so that the RAM's access, pulse-width, setup and bus-release times are all met.

All wait states are counted in clock cycles. Each RAM timing figure in nanoseconds is divided by the clock period and rounded up, with a floor of one cycle. Changing the clock or the memory speed grade therefore needs only new parameter values. A finished access is reported by a one-cycle `done` pulse, and a read's byte is presented on `rd_data` in that same cycle.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is applied, and whenever no access is in progress, the memory pins rest deselected: `mem_ce1_n`=1, `mem_ce2`=0, `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0. `done` is 0.
- R2: `mem_ce1_n` is low in exactly the cycles where `mem_ce2` is high, so the two selects are always both active or both inactive.
- R3: A read accepted at clock edge 0 holds the address, both selects and `mem_oe_n`=0 (with `mem_we_n`=1) for RD cycles, where RD is the largest of ceil(t_AA/P), ceil(t_OE/P) and ceil(t_RC/P), each at least 1. At edge RD the data bus is captured and the pins return to rest. `done`=1 and `rd_data` carry the byte in the cycle that follows.
- R4: A write accepted at edge 0 first holds the address and selects, with OE and WE high and no drive, for TC = max(ceil(t_OHZ/P), ceil(t_WHZ/P)) cycles. It then holds `mem_we_n`=0 with the byte driven for WC cycles. WC is the largest of ceil(t_WP/P), ceil(t_DW/P), ceil(t_AW/P)-TC and ceil(t_WC/P)-TC-1, where a difference below 1 counts as 1. One further cycle follows with WE high and the selects and drive held. `done` pulses in the cycle after that.
- R5: `mem_oe_n` is never low while `mem_we_n` is low, and it stays high for the whole of a write.
- R6: The controller drives the data bus only while WE is low or in the single recovery cycle after it, never while OE is low. It never drives while the RAM may still be driving the bus.
- R7: `mem_addr` never changes in a cycle in which `mem_we_n` is low or has just been low.
- R8: At the rising WE edge, the write pulse has lasted at least t_WP, the driven byte has been stable for at least t_DW, and the address has been stable for at least t_AW.
- R9: `done` is high for exactly one cycle per access. A request is accepted only when the block is at rest, and a request raised during an access is ignored.
- R10: The address and write byte are captured when the request is accepted. Host-side changes to them during the access do not alter the memory pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, taken only at rest |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | 17 | Host location |
| wr_data | input | 8 | Host write byte |
| rd_data | output | 8 | Byte captured by the last read |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 17 | RAM address lines |
| mem_ce1_n | output | 1 | RAM select, active low |
| mem_ce2 | output | 1 | RAM select, active high |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq_out | output | 8 | Byte toward the RAM data bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_in | input | 8 | Byte sampled from the RAM data bus |

## Verification
The bench builds the block with its default values: an 8 ns period and a 55 ns speed grade. These give RD=7, TC=4 and WC=5. At these values every wait count is several cycles long, so a count that is off by one lands a capture or a write edge inside the RAM model's 1 ns-resolved timing window. The model returns inverted data until both the access time and the output-enable time have elapsed, and it records contention against its bus-release windows. A shortened read, a shortened turnaround or an early drive therefore appears as wrong data or as bus contention.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_WSET = 3'd2,
    ST_WPUL = 3'd3,
    ST_WEND = 3'd4,
    ST_DONE = 3'd5
  } ctl_state_e;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // cycles still owed after 'used' cycles have elapsed, at least one
  function automatic int unsigned rem_after(input int unsigned total, input int unsigned used);
    return (total > used) ? total - used : 1;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
`timescale 1ns/1ps
module sram_ctrl_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
`timescale 1ns/1ps
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int RD_LOAD = 0,
  parameter int WS_LOAD = 0,
  parameter int WP_LOAD = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             wr_en,
  input  logic             expired,
  output ctl_state_e       state_q,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             accept,
  output logic             capture
);
  ctl_state_e state_d;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req) begin
        accept = 1'b1;
        load   = 1'b1;
        if (wr_en) begin
          state_d  = ST_WSET;
          load_val = CNT_W'(WS_LOAD);
        end else begin
          state_d  = ST_RD;
          load_val = CNT_W'(RD_LOAD);
        end
      end
      ST_RD: if (expired) begin
        capture = 1'b1;
        state_d = ST_DONE;
      end
      ST_WSET: if (expired) begin
        state_d  = ST_WPUL;
        load     = 1'b1;
        load_val = CNT_W'(WP_LOAD);
      end
      ST_WPUL: if (expired) state_d = ST_WEND;
      ST_WEND: state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/sram_ctrl_datapath.sv
`timescale 1ns/1ps
module sram_ctrl_datapath #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);
  logic [ADDR_W-1:0] addr_d;
  logic [DATA_W-1:0] wdata_d, rdata_d;

  always_comb begin
    addr_d  = accept  ? host_addr  : addr_q;
    wdata_d = accept  ? host_wdata : wdata_q;
    rdata_d = capture ? mem_rdata  : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
    end
  end
endmodule

// File: rtl/sram_async_ctrl.sv
`timescale 1ns/1ps
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned T_RC_NS  = 55,
  parameter int unsigned T_AA_NS  = 55,
  parameter int unsigned T_OE_NS  = 30,
  parameter int unsigned T_WC_NS  = 55,
  parameter int unsigned T_WP_NS  = 35,
  parameter int unsigned T_AW_NS  = 55,
  parameter int unsigned T_DW_NS  = 25,
  parameter int unsigned T_OHZ_NS = 30,
  parameter int unsigned T_WHZ_NS = 25,
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int unsigned P        = CLK_PERIOD_NS;
  localparam int unsigned RD_CYC   = umax(umax(ns_to_cyc(T_AA_NS, P), ns_to_cyc(T_OE_NS, P)),
                                          ns_to_cyc(T_RC_NS, P));
  localparam int unsigned TURN_CYC = umax(ns_to_cyc(T_OHZ_NS, P), ns_to_cyc(T_WHZ_NS, P));
  localparam int unsigned WP_CYC   = umax(umax(ns_to_cyc(T_WP_NS, P), ns_to_cyc(T_DW_NS, P)),
                                          umax(rem_after(ns_to_cyc(T_AW_NS, P), TURN_CYC),
                                               rem_after(ns_to_cyc(T_WC_NS, P), TURN_CYC + 1)));
  localparam int unsigned MAX_CYC  = umax(RD_CYC, umax(TURN_CYC, WP_CYC));
  localparam int CNT_W             = $clog2(MAX_CYC + 1);

  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ctl_state_e       state_q;
  logic             load, accept, capture, expired;
  logic [CNT_W-1:0] load_val;
  logic [DATA_W-1:0] rdata_q, wdata_q;
  logic [ADDR_W-1:0] addr_q;

  sram_ctrl_fsm #(
    .CNT_W  (CNT_W),
    .RD_LOAD(int'(RD_CYC) - 1),
    .WS_LOAD(int'(TURN_CYC) - 1),
    .WP_LOAD(int'(WP_CYC) - 1)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .req     (req),
    .wr_en   (wr_en),
    .expired (expired),
    .state_q (state_q),
    .load    (load),
    .load_val(load_val),
    .accept  (accept),
    .capture (capture)
  );

  sram_ctrl_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .load    (load),
    .load_val(load_val),
    .expired (expired)
  );

  sram_ctrl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .accept    (accept),
    .capture   (capture),
    .host_addr (addr),
    .host_wdata(wr_data),
    .mem_rdata (mem_dq_in),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .rdata_q   (rdata_q)
  );

  // memory pins decoded from the registered state
  logic selected;
  always_comb begin
    selected   = (state_q == ST_RD) || (state_q == ST_WSET) ||
                 (state_q == ST_WPUL) || (state_q == ST_WEND);
    mem_ce1_n  = !selected;
    mem_ce2    = selected;
    mem_oe_n   = (state_q != ST_RD);
    mem_we_n   = (state_q != ST_WPUL);
    mem_dq_oe  = (state_q == ST_WPUL) || (state_q == ST_WEND);
    mem_dq_out = wdata_q;
    mem_addr   = addr_q;
    done       = (state_q == ST_DONE);
    rd_data    = rdata_q;
  end
endmodule

// File: rtl/sram_async_ctrl_chk.sv
`timescale 1ns/1ps
module sram_async_ctrl_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce1_n,
  input logic              mem_ce2,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r2_selects_paired: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ce1_n == !mem_ce2);

  a_r5_we_oe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  a_r6_drive_needs_oe_high: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && !mem_ce1_n));

  a_r6_drive_starts_with_we: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && mem_dq_oe && !$past(mem_dq_oe)) |-> !mem_we_n);

  a_r7_addr_held_around_we: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && (!mem_we_n || !$past(mem_we_n))) |-> $stable(mem_addr));

  a_r10_wdata_held: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .done      (done),
  .mem_addr  (mem_addr),
  .mem_ce1_n (mem_ce1_n),
  .mem_ce2   (mem_ce2),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_out(mem_dq_out),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_async_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_async_ctrl_tb_top;
  localparam int P = 8;
  localparam int T_RC = 55, T_AA = 55, T_OE = 30, T_WC = 55, T_WP = 35;
  localparam int T_AW = 55, T_DW = 25, T_OHZ = 30, T_WHZ = 25;

  function automatic int cy(input int ns);
    int c;
    c = (ns + P - 1) / P;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  function automatic int rest(input int a, input int b);
    return (a - b < 1) ? 1 : a - b;
  endfunction

  localparam int RDC = mx(mx(cy(T_AA), cy(T_OE)), cy(T_RC));
  localparam int TC  = mx(cy(T_OHZ), cy(T_WHZ));
  localparam int WC  = mx(mx(cy(T_WP), cy(T_DW)), mx(rest(cy(T_AW), TC), rest(cy(T_WC), TC + 1)));

  logic clk, rst_n, req, wr_en, done;
  logic [16:0] addr, mem_addr;
  logic [7:0] wr_data, rd_data, mem_dq_out, mem_dq_in, mem_q;
  logic mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_dq_oe;

  int checks = 0, errors = 0;
  bit started = 0, finished = 0, contention = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  sram_async_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .done(done), .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n),
    .mem_ce2(mem_ce2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural RAM with timing and contention tracking
  logic [7:0] mstore [int];
  logic [7:0] shadow [int];
  function automatic logic [7:0] bg(input logic [16:0] a);
    return a[7:0] ^ {a[16:15], a[13:8]} ^ 8'h5A;
  endfunction

  logic sel;
  assign sel = !mem_ce1_n && mem_ce2;
  assign mem_dq_in = mem_dq_oe ? mem_dq_out : mem_q;

  longint t_addr = 0, t_oe_fall = 0, t_oe_rise = -1000, t_we_fall = 0, t_din = 0, t_sel = 0;

  always @(mem_addr) begin
    t_addr = $time;
    if (started) chk(!(sel && !mem_we_n), "R7 addr moved under WE", {31'd0, mem_we_n}, 32'd1);
  end
  always @(negedge mem_oe_n) t_oe_fall = $time;
  always @(posedge mem_oe_n) t_oe_rise = $time;
  always @(negedge mem_we_n) t_we_fall = $time;
  always @(posedge sel)      t_sel = $time;
  always @(mem_dq_out or mem_dq_oe) t_din = $time;

  always @(posedge mem_we_n) if (started && sel) begin
    chk(mem_dq_oe, "R6 no drive at WE rise", {31'd0, mem_dq_oe}, 32'd1);
    chk($time - t_we_fall >= T_WP, "R8 WE pulse", 32'($time - t_we_fall), T_WP);
    chk($time - t_din >= T_DW, "R8 data setup", 32'($time - t_din), T_DW);
    chk($time - t_addr >= T_AW, "R8 address setup", 32'($time - t_addr), T_AW);
    mstore[int'(mem_addr)] = mem_dq_out;
  end

  always begin
    #1;
    begin
      bit rd_act, valid, holdz;
      logic [7:0] v;
      rd_act = sel && mem_we_n && !mem_oe_n;
      valid  = rd_act && ($time - t_addr >= T_AA) && ($time - t_oe_fall >= T_OE) &&
               ($time - t_sel >= T_AA);
      v      = mstore.exists(int'(mem_addr)) ? mstore[int'(mem_addr)] : bg(mem_addr);
      mem_q  = valid ? v : ~v;
      holdz  = ($time - t_oe_rise < T_OHZ) || (!mem_oe_n && ($time - t_we_fall < T_WHZ));
      if (started && mem_dq_oe && (rd_act || holdz)) contention = 1;
    end
  end

  // ---------------- cycle-by-cycle reference of the pins
  // {ce1_n, ce2, oe_n, we_n, dq_oe, done}; R2 and R5 are encoded in every vector
  function automatic logic [5:0] exp_pins(input bit w, input int j);
    if (!w) begin
      if (j < RDC)  return 6'b010100;
      if (j == RDC) return 6'b101101;
      return 6'b101100;
    end
    if (j < TC)           return 6'b011100;
    if (j < TC + WC)      return 6'b011010;
    if (j == TC + WC)     return 6'b011110;
    if (j == TC + WC + 1) return 6'b101101;
    return 6'b101100;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [16:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : bg(a);
  endfunction

  // called at a negedge with the block at rest
  task automatic op(input bit w, input logic [16:0] a, input logic [7:0] d, input bit poke);
    int lat;
    string tag;
    logic [5:0] pins, e;
    lat = w ? TC + WC + 1 : RDC;
    tag = poke ? "R9 busy request" : (w ? "R4 write seq" : "R3 read seq");
    req = 1'b1; wr_en = w; addr = a; wr_data = d;
    for (int j = 0; j <= lat + 1; j++) begin
      @(negedge clk);
      pins = {mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe, done};
      e = exp_pins(w, j);
      chk(pins == e, tag, {26'd0, pins}, {26'd0, e});
      if (!mem_ce1_n) chk(mem_addr == a, "R10 address held", {15'd0, mem_addr}, {15'd0, a});
      if (mem_dq_oe)  chk(mem_dq_out == d, "R10 write byte held", {24'd0, mem_dq_out}, {24'd0, d});
      if (!w && j == RDC) chk(rd_data == exp_rd(a), "R3 read byte", {24'd0, rd_data}, {24'd0, exp_rd(a)});
      if (j == 0) begin
        req = poke;
        if (poke) begin wr_en = 1'b1; addr = a ^ 17'h1; wr_data = ~d; end
      end
      if (j == 2) req = 1'b0;
    end
    if (w) shadow[int'(a)] = d;
  endtask

  logic [16:0] alist [8];
  initial begin
    rst_n = 1'b0; req = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk({mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe, done} == 6'b101100,
        "R1 reset pins", {26'd0, mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe, done}, 32'h2C);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    started = 1;
    chk({mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe, done} == 6'b101100,
        "R1 rest pins", {26'd0, mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe, done}, 32'h2C);

    // write then read at scattered locations, including both ends of the range
    for (int i = 0; i < 8; i++) begin
      alist[i] = (i == 0) ? 17'h00000 : (i == 1) ? 17'h1FFFF : 17'($urandom);
      op(1'b1, alist[i], 8'($urandom), 1'b0);
      op(1'b0, alist[i], 8'h00, 1'b0);
    end
    // back-to-back reads, one at a never-written location
    for (int i = 7; i >= 0; i--) op(1'b0, alist[i], 8'h00, 1'b0);
    op(1'b0, 17'h0ABCD, 8'h00, 1'b0);
    // a read directly followed by a write, then read back (R6 turnaround)
    op(1'b0, alist[2], 8'h00, 1'b0);
    op(1'b1, alist[2], 8'hC3, 1'b0);
    op(1'b0, alist[2], 8'h00, 1'b0);
    // requests and host changes during a busy access are ignored (R9, R10)
    op(1'b1, 17'h01234, 8'h3C, 1'b1);
    op(1'b0, 17'h01234, 8'h00, 1'b0);
    op(1'b0, 17'h01235, 8'h00, 1'b1);
    op(1'b0, 17'h01235, 8'h00, 1'b0);
    repeat (2) @(negedge clk);
    chk(!contention, "R6 bus contention", {31'd0, contention}, 32'd0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * P);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule